// File: doc/BRIEF.md
# Zone-Protected TLB Lookup

This block translates a 32-bit virtual address with a fully associative set of translation entries. Each entry holds a tag word and a data word. The tag word carries a virtual page number, a page-size code and a valid flag. The data word carries a physical page number, write and execute permissions and a zone selector. Each entry also keeps an 8-bit owner tag, which is captured when its tag word is written. A lookup presents the address, an access kind, a user/supervisor flag, the current process ID and a 32-bit zone register. In the same cycle it returns exactly one of hit, miss or protection fault. It also returns the winning entry index and, on a hit, the physical page number and page-size code.

Software or a refill engine fills the entries through a simple side write port, one word per clock. Every page can have its own size, from 1 KB up to 16 MB, in steps of four. The zone register maps each entry to a 2-bit access policy. That policy can hide the entry from user code, keep the entry's own rights, or widen the rights.

Top module: `xlat_zone_tlb`

## Requirements
- R1: Tag-word bits 9:7 hold a size code c. The page size is 1 KB × 4^c (1 KB to 16 MB). An entry matches the address only on the bits at and above log2(page size). The same mask is applied to the address and to the tag word, so the tag's low page-number bits inside a large page are ignored.
- R2: An entry's 8-bit owner tag of zero matches every process ID. A nonzero owner tag matches only when it equals `cur_pid`.
- R3: Data-word bits 7:4 select zone z. The zone code for z is `zone_reg` bits [31−2z : 30−2z], so zone 0 is the top two bits.
- R4: Zone code 0 makes the entry invisible to user accesses, and the search then goes on to later entries. Supervisor accesses are unaffected.
- R5: Zone code 1 uses the entry's own write (data bit 8) and execute (data bit 9) flags. Code 2 grants write and execute to supervisor accesses only. Code 3 grants both to every access.
- R6: When the `ZONE_EN` parameter is 0, or the zone selector is not below `ZONE_CNT`, the zone code is taken as 1.
- R7: Access kind encodes 0 = read, 1 = write, 2 = fetch, 3 = read-like probe. Reads and probes never need rights. A write without write permission, or a fetch without execute permission, on the winning entry gives `lk_fault` (not a miss) and reports that entry's index.
- R8: When no valid, address-matching, owner-matching, visible entry exists, `lk_miss` is 1 and the index, page number and size outputs are 0.
- R9: Among several candidate entries, the lowest index wins, and only its rights decide between hit and fault.
- R10: The lookup is purely combinational. Exactly one of hit, miss and fault is 1. On a hit, `lk_ppn` is data bits 31:10 and `lk_size` is tag bits 9:7 of the winning entry. On a fault, both are 0.
- R11: Tag-word bit 6 is the valid flag. A tag write stores the word and captures `wr_tid` at the same clock edge. A data write leaves the owner tag unchanged. Reset clears all entries, so every lookup misses after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the entry store |
| rst_n | input | 1 | Active-low reset, clears all entries |
| wr_tag_en | input | 1 | Write `wr_word` as the tag word of entry `wr_idx` and capture `wr_tid` |
| wr_dat_en | input | 1 | Write `wr_word` as the data word of entry `wr_idx` |
| wr_idx | input | IW | Entry index for the side write |
| wr_word | input | 32 | Word to store |
| wr_tid | input | 8 | Owner tag captured with a tag write |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 probe |
| lk_user | input | 1 | 1 for a user-mode access |
| cur_pid | input | 8 | Current process ID |
| zone_reg | input | 32 | Sixteen 2-bit zone codes, zone 0 in bits 31:30 |
| lk_hit | output | 1 | Translation granted |
| lk_miss | output | 1 | No candidate entry |
| lk_fault | output | 1 | Candidate found but access not permitted |
| lk_idx | output | IW | Winning entry index (0 on miss) |
| lk_ppn | output | 22 | Physical page number on hit |
| lk_size | output | 3 | Page-size code on hit |

## Verification
The lookup outputs depend on their inputs in the same cycle, with no register on the path. A side write becomes visible to lookups only after the next rising clock edge. The bench therefore changes write controls and lookup inputs on the falling edge. It compares every lookup output 1 ns later, after all writes issued earlier have passed a rising edge. The expected result comes from a behavioural model that applies a divide-by-page-size comparison and an arithmetic zone extraction. Two instances, one with zones enabled and one without, are checked against that model.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  localparam int unsigned VA_W    = 32;
  localparam int unsigned PN_LSB  = 10;
  localparam int unsigned PN_W    = VA_W - PN_LSB;
  localparam int unsigned SZ_LSB  = 7;
  localparam int unsigned SZ_W    = 3;
  localparam int unsigned VLD_BIT = 6;
  localparam int unsigned XP_BIT  = 9;
  localparam int unsigned WP_BIT  = 8;
  localparam int unsigned ZS_LSB  = 4;
  localparam int unsigned ZS_W    = 4;
  localparam int unsigned PID_W   = 8;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_PROBE = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    ZN_HIDE_USER = 2'd0,
    ZN_ENTRY     = 2'd1,
    ZN_SUPV_ALL  = 2'd2,
    ZN_ALL       = 2'd3
  } zone_e;

  // Mask keeping the address bits that name the page for a size code.
  function automatic logic [VA_W-1:0] page_keep_mask(input logic [SZ_W-1:0] code);
    logic [VA_W-1:0] span;
    span = 32'h0000_0400 << {code, 1'b0};
    return ~(span - 32'd1);
  endfunction

  // Two-bit policy for zone sel; zone 0 is the most significant pair.
  function automatic zone_e zone_field(input logic [31:0] zr, input logic [ZS_W-1:0] sel);
    logic [31:0] sh;
    sh = zr >> (5'd30 - {sel, 1'b0});
    return zone_e'(sh[1:0]);
  endfunction

endpackage

// File: rtl/xlat_entry_store.sv
module xlat_entry_store #(
  parameter int unsigned N  = 64,
  parameter int unsigned IW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_tag_en,
  input  logic          wr_dat_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [31:0]   wr_word,
  input  logic [7:0]    wr_tid,
  output logic [31:0]   tag_q [N],
  output logic [31:0]   dat_q [N],
  output logic [7:0]    tid_q [N]
);

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_ent
      logic sel_here;
      assign sel_here = (wr_idx == IW'(g));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          tag_q[g] <= '0;
          tid_q[g] <= '0;
        end else if (wr_tag_en && sel_here) begin
          tag_q[g] <= wr_word;
          tid_q[g] <= wr_tid;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          dat_q[g] <= '0;
        end else if (wr_dat_en && sel_here) begin
          dat_q[g] <= wr_word;
        end
      end
    end
  endgenerate

  // R11
  tag_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tag_en && (32'(wr_idx) < N)) |=>
      (tag_q[$past(wr_idx)] == $past(wr_word)) && (tid_q[$past(wr_idx)] == $past(wr_tid)));

  // R11
  dat_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dat_en && (32'(wr_idx) < N)) |=> (dat_q[$past(wr_idx)] == $past(wr_word)));

endmodule

// File: rtl/xlat_entry_cmp.sv
module xlat_entry_cmp
  import xlat_pkg::*;
#(
  parameter bit          ZONE_EN  = 1'b1,
  parameter int unsigned ZONE_CNT = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] ent_tag,
  input  logic [31:0] ent_dat,
  input  logic [7:0]  ent_tid,
  input  logic [31:0] lk_vaddr,
  input  logic [7:0]  cur_pid,
  input  logic [31:0] zone_reg,
  input  logic        lk_user,
  input  logic [1:0]  lk_kind,
  output logic        cand,
  output zone_e       zcode,
  output logic        rights_ok
);

  logic [VA_W-1:0] keep;
  logic            addr_eq;
  logic            pid_ok;
  logic [ZS_W-1:0] zsel;
  logic            zone_live;
  logic            hidden;
  logic            may_write;
  logic            may_exec;
  logic            unused_dat;

  assign unused_dat = ^{ent_dat[31:10], ent_dat[3:0]};

  // Address compare on page-number bits only.
  assign keep    = page_keep_mask(ent_tag[SZ_LSB +: SZ_W]);
  assign addr_eq = (((lk_vaddr ^ ent_tag) & keep) == '0);

  // Owner tag zero is a wildcard.
  assign pid_ok  = (ent_tid == '0) || (ent_tid == cur_pid);

  // Zone policy, falling back to "entry rights" when out of range or disabled.
  assign zsel      = ent_dat[ZS_LSB +: ZS_W];
  assign zone_live = ZONE_EN && ({28'd0, zsel} < ZONE_CNT);
  assign zcode     = zone_live ? zone_field(zone_reg, zsel) : ZN_ENTRY;
  assign hidden    = (zcode == ZN_HIDE_USER) && lk_user;

  assign cand = ent_tag[VLD_BIT] && addr_eq && pid_ok && !hidden;

  assign may_write = ent_dat[WP_BIT] || (zcode == ZN_ALL) || ((zcode == ZN_SUPV_ALL) && !lk_user);
  assign may_exec  = ent_dat[XP_BIT] || (zcode == ZN_ALL) || ((zcode == ZN_SUPV_ALL) && !lk_user);

  always_comb begin
    unique case (acc_e'(lk_kind))
      ACC_STORE: rights_ok = may_write;
      ACC_FETCH: rights_ok = may_exec;
      default:   rights_ok = 1'b1;
    endcase
  end

  // R4
  hidden_from_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_user && (zcode == ZN_HIDE_USER)) |-> !cand);

  // R5
  zone_all_grants_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cand && (zcode == ZN_ALL)) |-> rights_ok);

  // R6
  zone_off_entry_rights_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !zone_live |-> (rights_ok == ((acc_e'(lk_kind) == ACC_STORE) ? ent_dat[WP_BIT] :
                                  (acc_e'(lk_kind) == ACC_FETCH) ? ent_dat[XP_BIT] : 1'b1)));

endmodule

// File: rtl/xlat_prio_pick.sv
module xlat_prio_pick #(
  parameter int unsigned N  = 64,
  parameter int unsigned IW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] pick
);

  always_comb begin
    any  = |req;
    pick = '0;
    for (int i = int'(N) - 1; i >= 0; i--) begin
      if (req[i]) pick = IW'(i);
    end
  end

  // R9
  pick_is_requested_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> req[pick]);

endmodule

// File: rtl/xlat_zone_tlb.sv
module xlat_zone_tlb
  import xlat_pkg::*;
#(
  parameter int unsigned N_ENT    = 64,
  parameter bit          ZONE_EN  = 1'b1,
  parameter int unsigned ZONE_CNT = 16,
  localparam int unsigned IW      = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_tag_en,
  input  logic            wr_dat_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [31:0]     wr_word,
  input  logic [7:0]      wr_tid,
  input  logic [31:0]     lk_vaddr,
  input  logic [1:0]      lk_kind,
  input  logic            lk_user,
  input  logic [7:0]      cur_pid,
  input  logic [31:0]     zone_reg,
  output logic            lk_hit,
  output logic            lk_miss,
  output logic            lk_fault,
  output logic [IW-1:0]   lk_idx,
  output logic [PN_W-1:0] lk_ppn,
  output logic [SZ_W-1:0] lk_size
);

  logic [31:0]      tag_q [N_ENT];
  logic [31:0]      dat_q [N_ENT];
  logic [7:0]       tid_q [N_ENT];
  logic [N_ENT-1:0] cand_vec;
  logic [N_ENT-1:0] ok_vec;
  zone_e            zc_vec [N_ENT];
  logic             any_cand;
  logic [IW-1:0]    win;
  logic             win_ok;

  xlat_entry_store #(.N(N_ENT), .IW(IW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_tag_en (wr_tag_en),
    .wr_dat_en (wr_dat_en),
    .wr_idx    (wr_idx),
    .wr_word   (wr_word),
    .wr_tid    (wr_tid),
    .tag_q     (tag_q),
    .dat_q     (dat_q),
    .tid_q     (tid_q)
  );

  genvar g;
  generate
    for (g = 0; g < N_ENT; g++) begin : g_slice
      xlat_entry_cmp #(.ZONE_EN(ZONE_EN), .ZONE_CNT(ZONE_CNT)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .ent_tag   (tag_q[g]),
        .ent_dat   (dat_q[g]),
        .ent_tid   (tid_q[g]),
        .lk_vaddr  (lk_vaddr),
        .cur_pid   (cur_pid),
        .zone_reg  (zone_reg),
        .lk_user   (lk_user),
        .lk_kind   (lk_kind),
        .cand      (cand_vec[g]),
        .zcode     (zc_vec[g]),
        .rights_ok (ok_vec[g])
      );
    end
  endgenerate

  xlat_prio_pick #(.N(N_ENT), .IW(IW)) u_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (cand_vec),
    .any   (any_cand),
    .pick  (win)
  );

  // Rights of the first candidate alone decide hit versus fault.
  assign win_ok   = ok_vec[win];
  assign lk_hit   = any_cand && win_ok;
  assign lk_fault = any_cand && !win_ok;
  assign lk_miss  = !any_cand;
  assign lk_idx   = any_cand ? win : '0;
  assign lk_ppn   = lk_hit ? dat_q[win][VA_W-1:PN_LSB] : '0;
  assign lk_size  = lk_hit ? tag_q[win][SZ_LSB +: SZ_W] : '0;

  // R10
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({lk_hit, lk_miss, lk_fault}) == 1);

  // R8
  miss_no_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |-> ((cand_vec == '0) && (lk_idx == '0) && (lk_ppn == '0)));

  // R9
  lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit || lk_fault) |-> ((cand_vec & ~({N_ENT{1'b1}} << lk_idx)) == '0));

  // R7
  read_never_faults_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((acc_e'(lk_kind) == ACC_LOAD) || (acc_e'(lk_kind) == ACC_PROBE)) && !lk_miss) |-> lk_hit);

  // R4
  user_hit_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && lk_user) |-> (zc_vec[lk_idx] != ZN_HIDE_USER));

endmodule

// File: tb/xlat_zone_tlb_tb.sv
module xlat_zone_tlb_tb;

  localparam int N  = 8;
  localparam int ZC = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_tag_en = 1'b0, wr_dat_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [31:0] wr_word = '0;
  logic [7:0]  wr_tid = '0;
  logic [31:0] lk_vaddr = '0;
  logic [1:0]  lk_kind = '0;
  logic        lk_user = 1'b0;
  logic [7:0]  cur_pid = '0;
  logic [31:0] zone_reg = '0;

  logic a_hit, a_miss, a_fault, b_hit, b_miss, b_fault;
  logic [2:0]  a_idx, b_idx, a_sz, b_sz;
  logic [21:0] a_ppn, b_ppn;

  int n_run = 0, n_fail = 0, cyc = 0;

  logic [31:0] m_tag [N];
  logic [31:0] m_dat [N];
  logic [7:0]  m_tid [N];

  always #2.5 clk = ~clk;

  xlat_zone_tlb #(.N_ENT(N), .ZONE_EN(1'b1), .ZONE_CNT(ZC)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_tag_en(wr_tag_en), .wr_dat_en(wr_dat_en),
    .wr_idx(wr_idx), .wr_word(wr_word), .wr_tid(wr_tid), .lk_vaddr(lk_vaddr),
    .lk_kind(lk_kind), .lk_user(lk_user), .cur_pid(cur_pid), .zone_reg(zone_reg),
    .lk_hit(a_hit), .lk_miss(a_miss), .lk_fault(a_fault), .lk_idx(a_idx),
    .lk_ppn(a_ppn), .lk_size(a_sz));

  xlat_zone_tlb #(.N_ENT(N), .ZONE_EN(1'b0), .ZONE_CNT(ZC)) u_dut_nz (
    .clk(clk), .rst_n(rst_n), .wr_tag_en(wr_tag_en), .wr_dat_en(wr_dat_en),
    .wr_idx(wr_idx), .wr_word(wr_word), .wr_tid(wr_tid), .lk_vaddr(lk_vaddr),
    .lk_kind(lk_kind), .lk_user(lk_user), .cur_pid(cur_pid), .zone_reg(zone_reg),
    .lk_hit(b_hit), .lk_miss(b_miss), .lk_fault(b_fault), .lk_idx(b_idx),
    .lk_ppn(b_ppn), .lk_size(b_sz));

  // Behavioural model: {hit, miss, fault, idx[3], ppn[22], size[3]}
  function automatic logic [30:0] model(input bit zen, input logic [31:0] va, input int kind,
                                        input bit usr, input logic [7:0] pid, input logic [31:0] zr);
    for (int i = 0; i < N; i++) begin
      longint span, pv, ev;
      int code, sel, zc;
      bit w, x, ok;
      if (!m_tag[i][6]) continue;
      code = int'(m_tag[i][9:7]);
      span = 1024;
      for (int k = 0; k < code; k++) span = span * 4;
      pv = longint'(va) / span;
      ev = longint'(m_tag[i] & 32'hFFFF_FC00) / span;
      if (pv != ev) continue;
      if (m_tid[i] != 8'd0 && m_tid[i] != pid) continue;
      sel = int'(m_dat[i][7:4]);
      if (zen && sel < ZC) begin
        longint dv = 1;
        for (int k = 0; k < 15 - sel; k++) dv = dv * 4;
        zc = int'((longint'(zr) / dv) % 4);
      end else zc = 1;
      if (zc == 0 && usr) continue;
      w = m_dat[i][8] || zc == 3 || (zc == 2 && !usr);
      x = m_dat[i][9] || zc == 3 || (zc == 2 && !usr);
      ok = (kind == 1) ? w : (kind == 2) ? x : 1'b1;
      if (ok) return {3'b100, 3'(i), m_dat[i][31:10], m_tag[i][9:7]};
      return {3'b001, 3'(i), 22'd0, 3'd0};
    end
    return {3'b010, 28'd0};
  endfunction

  task automatic chk(input logic [30:0] got, input logic [30:0] exp, input string rq, input string who);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s [%s] va=%h kind=%0d user=%0d pid=%h zr=%h got=%h exp=%h",
               rq, who, lk_vaddr, lk_kind, lk_user, cur_pid, zone_reg, got, exp);
    end
  endtask

  task automatic probe(input logic [31:0] va, input int kind, input bit usr, input string rq);
    @(negedge clk);
    lk_vaddr = va; lk_kind = 2'(kind); lk_user = usr;
    #1;
    chk({a_hit, a_miss, a_fault, a_idx, a_ppn, a_sz}, model(1'b1, va, kind, usr, cur_pid, zone_reg), rq, "zones on");
    chk({b_hit, b_miss, b_fault, b_idx, b_ppn, b_sz}, model(1'b0, va, kind, usr, cur_pid, zone_reg), rq, "zones off");
  endtask

  task automatic put_tag(input int i, input logic [31:0] w, input logic [7:0] tid);
    @(negedge clk);
    wr_tag_en = 1'b1; wr_idx = 3'(i); wr_word = w; wr_tid = tid;
    m_tag[i] = w; m_tid[i] = tid;
    @(negedge clk);
    wr_tag_en = 1'b0;
  endtask

  // Drives a different wr_tid on purpose: a data write must not touch the owner tag (R11).
  task automatic put_dat(input int i, input logic [31:0] w);
    @(negedge clk);
    wr_dat_en = 1'b1; wr_idx = 3'(i); wr_word = w; wr_tid = 8'hC3;
    m_dat[i] = w;
    @(negedge clk);
    wr_dat_en = 1'b0;
  endtask

  task automatic clear_all();
    for (int i = 0; i < N; i++) put_tag(i, 32'd0, 8'd0);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_tag[i] = '0; m_dat[i] = '0; m_tid[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11: reset leaves every entry invalid, all lookups miss
    cur_pid = 8'h00; zone_reg = 32'h5555_5555;
    for (int k = 0; k < 4; k++) probe(32'h0000_0000 + 32'(k) * 32'h1234_5678, k, k[0], "R11 reset");

    // R1: every size code, boundaries inside and just outside the page
    for (int c = 0; c < 8; c++) begin
      logic [31:0] base, sz, tg;
      sz = 32'h400 << (2 * c);
      base = 32'h0A00_0000;
      clear_all();
      tg = ((base + (sz >> 1)) & 32'hFFFF_FC00) | (32'(c) << 7) | 32'h40;
      put_tag(3, tg, 8'd0);
      put_dat(3, 32'h1234_5C00 | 32'h300);
      for (int k = 0; k < 3; k++) begin
        probe(base, k, 1'b0, "R1");
        probe(base + sz - 1, k, 1'b0, "R1");
        probe(base + sz, k, 1'b0, "R1 R8");
        probe(base - 1, k, 1'b0, "R1 R8");
        probe(base + (sz >> 1) + 7, k, 1'b1, "R1 R10");
      end
    end

    // R2: owner tag wildcard and exact match, with owner kept across a data write (R11)
    clear_all();
    for (int t = 0; t < 3; t++) begin
      logic [7:0] tv;
      tv = (t == 0) ? 8'h00 : (t == 1) ? 8'h05 : 8'hFF;
      put_tag(1, 32'h0040_0000 | (32'd1 << 7) | 32'h40, tv);
      put_dat(1, 32'hBEEF_0000 | 32'h100);
      for (int p = 0; p < 4; p++) begin
        cur_pid = (p == 0) ? 8'h00 : (p == 1) ? 8'h05 : (p == 2) ? 8'h06 : 8'hFF;
        probe(32'h0040_0ABC, 0, 1'b0, "R2");
        probe(32'h0040_0ABC, 1, 1'b1, "R2 R11");
      end
    end
    cur_pid = 8'h00;

    // R3/R4/R5/R6/R7: all rights, every zone selector, every zone code
    clear_all();
    put_tag(2, 32'h7003_0000 | (32'd3 << 7) | 32'h40, 8'd0);
    for (int wx = 0; wx < 4; wx++) begin
      for (int sel = 0; sel < 16; sel++) begin
        put_dat(2, 32'h0ABC_DC00 | (32'(wx) << 8) | (32'(sel) << 4));
        for (int code = 0; code < 4; code++) begin
          logic [31:0] zr;
          zr = {16{2'(~code)}};
          zr[31 - 2 * sel -: 2] = 2'(code);
          zone_reg = zr;
          for (int k = 0; k < 4; k++) begin
            probe(32'h7003_1234, k, 1'b0, "R3/R5/R6/R7");
            probe(32'h7003_FFF0, k, 1'b1, "R3/R4/R5/R6/R7");
          end
        end
      end
    end

    // R9 and R4: overlapping entries, lowest visible index wins, hidden entry skipped for user
    clear_all();
    zone_reg = 32'h5555_5555;
    zone_reg[27:26] = 2'd0;   // zone 2 hides from user
    zone_reg[25:24] = 2'd3;   // zone 3 grants all
    put_tag(1, 32'h3000_0000 | (32'd2 << 7) | 32'h40, 8'd0);
    put_dat(1, 32'h1111_1000 | (32'd2 << 4));
    put_tag(5, 32'h3000_0000 | (32'd2 << 7) | 32'h40, 8'd0);
    put_dat(5, 32'h5555_5000 | (32'd3 << 4));
    put_tag(6, 32'h3000_0000 | (32'd2 << 7) | 32'h40, 8'd0);
    put_dat(6, 32'h6666_6000 | 32'h100 | (32'd1 << 4));
    for (int k = 0; k < 3; k++) begin
      probe(32'h3000_0100, k, 1'b0, "R9 R7");
      probe(32'h3000_0100, k, 1'b1, "R4 R9");
    end
    put_tag(1, 32'h0, 8'd0);
    for (int k = 0; k < 3; k++) probe(32'h3000_0200, k, 1'b0, "R9");
    put_tag(5, 32'h0, 8'd0);
    for (int k = 0; k < 3; k++) probe(32'h3000_0300, k, 1'b1, "R9");
    probe(32'h3001_0000, 0, 1'b0, "R8");

    finish_run();
  end

endmodule